// File: doc/BRIEF.md
# Predicated Wide-Shift Vector Unit

This unit applies a logical left shift to every active element of a vector operand. It takes the shift counts from a second vector that is viewed as 64-bit lanes. Elements are 8, 16 or 32 bits wide, selected per request by a 2-bit size code, so several narrow elements read the same 64-bit lane. Every bit of a lane counts toward the amount, and the amount saturates at the element width. A count of the element width or more therefore clears the element; it does not wrap.

A byte-granular predicate marks which elements take part. Elements that are not active return the operand unchanged. The reserved size code raises an illegal-size flag instead of producing a shifted result. The result, the flag and an output strobe are registered one clock after an input strobe. Between strobes the result register holds its value.

Top module: `wshift_unit`

## Requirements
- R1: Size code 2'b00 selects 8-bit elements, 2'b01 selects 16-bit elements and 2'b10 selects 32-bit elements. Element e of a vector occupies bits [e*W +: W], where W is the element width.
- R2: Element e takes its count from 64-bit lane k = (e*W)/64, which occupies bits [64*k +: 64] of the amount vector. All elements inside one lane share the same count.
- R3: The effective count is the unsigned minimum of the whole 64-bit lane value and W. A lane value of W or more, including any value with upper bits set, yields an element of zero.
- R4: An active element becomes the operand element shifted left by the effective count, with zeros entering at bit 0.
- R5: Predicate bit i belongs to byte i (bits [8*i +: 8]). An element is active exactly when the predicate bit of its lowest byte, bit e*W/8, is 1. The other predicate bits inside the element have no effect.
- R6: An inactive element of the result equals the corresponding operand element.
- R7: When no element is active for the selected size, the result equals the operand.
- R8: For size code 2'b11, the illegal-size flag is 1 in the output cycle and the result equals the operand unchanged.
- R9: out_valid equals in_valid from the previous clock. The result and the flag belong to that cycle. The flag is 0 whenever out_valid is 0. The result register holds its value when no input is strobed.
- R10: After a synchronous reset, out_valid, the flag and the result are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| size_code | input | 2 | Element size select |
| opnd | input | VLEN | Operand vector |
| amt | input | VLEN | Shift-count vector, 64-bit lanes |
| pred | input | VLEN/8 | Per-byte predicate |
| out_valid | output | 1 | Result strobe |
| result | output | VLEN | Shifted vector |
| bad_size | output | 1 | Illegal size code seen |

## Verification
The bench sets lane values to 0, W-1, W, W+1, and to small values with high bits set. A design that uses only the low lane bits, or that wraps the count modulo W, returns a nonzero element where zero is expected. Some predicate patterns set only the non-leading bits of each element; a unit that ORs all bits of an element would shift elements that must stay unchanged. Byte and halfword runs with distinct per-lane counts expose a wrong lane index, because elements would then shift by a neighbouring lane's count. Reserved-size requests and all-zero predicates check that the operand passes through and that the flag is raised only for the reserved code.

// File: rtl/wshift_pkg.sv
package wshift_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } esz_t;

  localparam int NUM_SIZES = 3;
  localparam int LANE_W    = 64;
endpackage

// File: rtl/wshift_amt_sat.sv
// Clamps one 64-bit count lane to the element width (R3).
module wshift_amt_sat #(
  parameter int EW = 8,
  parameter int AW = $clog2(EW + 1)
) (
  input  logic [63:0]   lane,
  output logic [AW-1:0] amt_sat
);
  always_comb begin
    if (lane >= 64'(EW)) amt_sat = AW'(EW);
    else                 amt_sat = lane[AW-1:0];
  end
endmodule

// File: rtl/wshift_elem.sv
// One element: shift with zero fill when active, pass-through otherwise.
module wshift_elem #(
  parameter int EW = 8,
  parameter int AW = $clog2(EW + 1)
) (
  input  logic [EW-1:0] x,
  input  logic [AW-1:0] sh,
  input  logic          act,
  output logic [EW-1:0] y
);
  always_comb begin
    if (!act)                 y = x;
    else if (sh >= AW'(EW))   y = '0;
    else                      y = x << sh;
  end
endmodule

// File: rtl/wshift_plane.sv
// Full-vector result for one element width.
module wshift_plane #(
  parameter int VLEN = 256,
  parameter int EW   = 8
) (
  input  logic [VLEN-1:0]   opnd,
  input  logic [VLEN-1:0]   amt,
  input  logic [VLEN/8-1:0] pred,
  output logic [VLEN-1:0]   res
);
  localparam int NE  = VLEN / EW;
  localparam int NL  = VLEN / 64;
  localparam int EPL = 64 / EW;
  localparam int BPE = EW / 8;
  localparam int AW  = $clog2(EW + 1);

  logic [NE-1:0] act;
  logic          any_act;
  logic [AW-1:0] sh [NL];

  // R5: leading byte's predicate bit decides activity
  always_comb begin
    for (int e = 0; e < NE; e++) act[e] = pred[e*BPE];
  end
  assign any_act = |act;

  genvar l, e;
  generate
    for (l = 0; l < NL; l++) begin : g_lane
      // R7: no active element -> counts treated as zero
      wshift_amt_sat #(.EW(EW), .AW(AW)) u_sat (
        .lane    (any_act ? amt[l*64 +: 64] : 64'd0),
        .amt_sat (sh[l])
      );
    end
    for (e = 0; e < NE; e++) begin : g_elem
      // R2: element e reads lane e/EPL
      wshift_elem #(.EW(EW), .AW(AW)) u_el (
        .x   (opnd[e*EW +: EW]),
        .sh  (sh[e/EPL]),
        .act (act[e]),
        .y   (res[e*EW +: EW])
      );
    end
  endgenerate
endmodule

// File: rtl/wshift_unit.sv
module wshift_unit
  import wshift_pkg::*;
#(
  parameter int VLEN = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        size_code,
  input  logic [VLEN-1:0]   opnd,
  input  logic [VLEN-1:0]   amt,
  input  logic [VLEN/8-1:0] pred,
  output logic              out_valid,
  output logic [VLEN-1:0]   result,
  output logic              bad_size
);
  localparam int PB = VLEN / 8;

  esz_t            sz;
  logic [VLEN-1:0] plane_res [NUM_SIZES];
  logic [VLEN-1:0] nxt;

  assign sz = esz_t'(size_code);

  genvar gi;
  generate
    for (gi = 0; gi < NUM_SIZES; gi++) begin : g_plane
      // R1: plane gi works on 8<<gi bit elements
      wshift_plane #(.VLEN(VLEN), .EW(8 << gi)) u_plane (
        .opnd (opnd),
        .amt  (amt),
        .pred (pred),
        .res  (plane_res[gi])
      );
    end
  endgenerate

  always_comb begin
    case (sz)
      SZ_BYTE: nxt = plane_res[0];
      SZ_HALF: nxt = plane_res[1];
      SZ_WORD: nxt = plane_res[2];
      default: nxt = opnd;      // R8: reserved code leaves operand intact
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      bad_size  <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      bad_size  <= in_valid && (sz == SZ_RSVD);
      if (in_valid) result <= nxt;
    end
  end

  p_valid_follow_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(in_valid)));

  p_flag_with_valid_r9: assert property (@(posedge clk) disable iff (rst)
    bad_size |-> out_valid);

  p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));

  p_rsvd_pass_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && $past(size_code) == 2'b11)
      |-> (bad_size && result == $past(opnd)));

  p_no_active_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && $past(size_code) != 2'b11
       && $past(pred) == {PB{1'b0}})
      |-> (result == $past(opnd)));
endmodule

// File: tb/wshift_unit_test.sv
module wshift_unit_test;
  localparam int VLEN       = 256;
  localparam int PB         = VLEN / 8;
  localparam int NL         = VLEN / 64;
  localparam int CLK_PERIOD = 10;

  logic            clk = 1'b0;
  logic            rst;
  logic            in_valid;
  logic [1:0]      size_code;
  logic [VLEN-1:0] opnd, amt;
  logic [PB-1:0]   pred;
  logic            out_valid, bad_size;
  logic [VLEN-1:0] result;

  int n_cmp = 0;
  int n_bad = 0;
  logic [VLEN-1:0] last_res;

  always #(CLK_PERIOD/2) clk = ~clk;

  wshift_unit #(.VLEN(VLEN)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .size_code(size_code),
    .opnd(opnd), .amt(amt), .pred(pred),
    .out_valid(out_valid), .result(result), .bad_size(bad_size)
  );

  // Behavioural model of R1..R7, bit by bit
  function automatic logic [VLEN-1:0] model(input logic [1:0] sz,
      input logic [VLEN-1:0] op, input logic [VLEN-1:0] am,
      input logic [PB-1:0] pr);
    logic [VLEN-1:0] r;
    int w, ne;
    bit any;
    r = op;
    if (sz == 2'b11) return op;
    w = 8 << sz;
    ne = VLEN / w;
    any = 0;
    for (int e = 0; e < ne; e++) if (pr[e*w/8]) any = 1;
    if (!any) return op;
    for (int e = 0; e < ne; e++) begin
      if (pr[e*w/8]) begin
        logic [63:0] ln;
        int s;
        ln = am[(e*w/64)*64 +: 64];
        s = (ln >= 64'(w)) ? w : int'(ln);
        for (int b = 0; b < w; b++)
          r[e*w+b] = (b >= s) ? op[e*w+b-s] : 1'b0;
      end
    end
    return r;
  endfunction

  function automatic logic [VLEN-1:0] rnd_vec();
    logic [VLEN-1:0] v;
    for (int i = 0; i < VLEN/32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [PB-1:0] rnd_pred();
    logic [PB-1:0] p;
    for (int i = 0; i < PB; i++) p[i] = ($urandom_range(0, 2) != 0);
    return p;
  endfunction

  function automatic logic [VLEN-1:0] rnd_amt(input int w);
    logic [VLEN-1:0] v;
    for (int k = 0; k < NL; k++) begin
      case ($urandom_range(0, 6))
        0: v[k*64 +: 64] = 64'd0;
        1: v[k*64 +: 64] = 64'(w - 1);
        2: v[k*64 +: 64] = 64'(w);
        3: v[k*64 +: 64] = 64'(w + 1);
        4: v[k*64 +: 64] = {1'b1, 31'($urandom), 32'($urandom_range(0, 3))};
        5: v[k*64 +: 64] = 64'($urandom_range(0, w - 1));
        default: v[k*64 +: 64] = {$urandom, $urandom};
      endcase
    end
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic do_op(input logic v, input logic [1:0] sz,
                       input logic [VLEN-1:0] op, input logic [VLEN-1:0] am,
                       input logic [PB-1:0] pr, input string tag);
    logic [VLEN-1:0] exp_res;
    logic exp_bad;
    in_valid = v; size_code = sz; opnd = op; amt = am; pred = pr;
    exp_res = v ? model(sz, op, am, pr) : last_res;
    exp_bad = v && (sz == 2'b11);
    @(posedge clk);
    @(negedge clk);
    chk(out_valid == v, "R9", "out_valid", VLEN'(out_valid), VLEN'(v));
    chk(bad_size == exp_bad, v ? "R8" : "R9", "bad_size",
        VLEN'(bad_size), VLEN'(exp_bad));
    chk(result == exp_res, v ? tag : "R9", "result", result, exp_res);
    last_res = exp_res;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [VLEN-1:0] v, a;
    logic [PB-1:0]   p;
    rst = 1'b1; in_valid = 1'b0; size_code = 2'b00;
    opnd = '0; amt = '0; pred = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    chk(out_valid == 1'b0, "R10", "out_valid", VLEN'(out_valid), '0);
    chk(bad_size == 1'b0, "R10", "bad_size", VLEN'(bad_size), '0);
    chk(result == '0, "R10", "result", result, '0);
    rst = 1'b0;
    last_res = '0;

    // R1: every legal size, all elements active, moderate counts
    for (int s = 0; s < 3; s++) begin
      a = '0;
      for (int k = 0; k < NL; k++) a[k*64 +: 64] = 64'(k + 1);
      do_op(1'b1, 2'(s), rnd_vec(), a, '1, "R1");
    end

    // R2: byte and halfword elements sharing distinct per-lane counts
    for (int s = 0; s < 2; s++) begin
      a = '0;
      for (int k = 0; k < NL; k++) a[k*64 +: 64] = 64'(k * 2 + 1);
      do_op(1'b1, 2'(s), '1, a, '1, "R2");
    end

    // R3: boundary lane values for each size
    for (int s = 0; s < 3; s++) begin
      int w;
      w = 8 << s;
      a = '0;
      a[0 +: 64]   = 64'(w - 1);
      a[64 +: 64]  = 64'(w);
      a[128 +: 64] = 64'h0000_0001_0000_0000;
      a[192 +: 64] = 64'h8000_0000_0000_0002;
      do_op(1'b1, 2'(s), rnd_vec(), a, '1, "R3");
    end

    // R5: only non-leading predicate bits set -> word elements untouched
    p = '0;
    for (int i = 0; i < PB; i++) p[i] = (i % 4 != 0);
    do_op(1'b1, 2'b10, rnd_vec(), rnd_amt(32), p, "R5");
    // R5: leading bit alone activates, mixed with inactive neighbours
    p = '0;
    for (int i = 0; i < PB; i++) p[i] = (i % 8 == 0) || (i % 8 == 5);
    do_op(1'b1, 2'b10, rnd_vec(), rnd_amt(32), p, "R5");

    // R6: alternating active halfwords
    p = '0;
    for (int i = 0; i < PB; i++) p[i] = (i % 4 == 0);
    do_op(1'b1, 2'b01, rnd_vec(), rnd_amt(16), p, "R6");

    // R7: no active element
    for (int s = 0; s < 3; s++) do_op(1'b1, 2'(s), rnd_vec(), rnd_amt(8 << s), '0, "R7");

    // R8: reserved size
    do_op(1'b1, 2'b11, rnd_vec(), rnd_amt(8), '1, "R8");
    do_op(1'b1, 2'b11, rnd_vec(), '0, rnd_pred(), "R8");

    // R9: idle cycles hold the result
    do_op(1'b0, 2'b00, rnd_vec(), rnd_amt(8), '1, "R9");
    do_op(1'b0, 2'b11, rnd_vec(), rnd_amt(8), '1, "R9");

    // R4 with R6: random mix of sizes, predicates, lanes and idle cycles
    for (int n = 0; n < 1500; n++) begin
      logic [1:0] s;
      s = 2'($urandom_range(0, 3));
      v = rnd_vec();
      a = rnd_amt(s == 2'b11 ? 8 : (8 << s));
      p = ($urandom_range(0, 15) == 0) ? '0 : rnd_pred();
      do_op(($urandom_range(0, 4) != 0), s, v, a, p, "R4");
    end

    in_valid = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule